// File: doc/BRIEF.md
# Character-Row Vertical Timing Counter

This block produces the vertical timing of a character-cell text display. It takes one pulse per finished scan line and counts those pulses in an internal scan-line counter, which spans one character row. Each time that counter wraps, a 4-bit row counter steps once. The row counter has a single carry, at its all-ones value, and a one-bit phase register selects which value the counter reloads after that carry. In the active phase the counter reloads 0, so it runs 0..15 and gives 16 displayed rows. In the blanked retrace phase it reloads 12, so it runs 12..15 and gives 4 rows.

With the default parameters a row is 13 scan lines and a frame is 20 rows, which is 260 scan lines. That suits 60 Hz operation. The phase is brought out as an active-low display flag. A single-cycle frame-start pulse marks the return from retrace to the active phase. Sync shaping and pixel serialisation are handled by other blocks.

Top module: `row_vtiming`

## Requirements
- R1: While rst_ni is low, and after its release until the first line pulse, row_o is 0, vdisp_no is 0 (active phase) and frame_start_o is 0. The internal scan-line count also restarts at 0.
- R2: row_o steps only on the clock edge that samples the 13th line_adv_i pulse since the previous row step (or since reset). A cycle with line_adv_i low changes neither row_o nor vdisp_no.
- R3: While vdisp_no is 0, row_o counts 0 through 15, one row per 13 line pulses.
- R4: On the row step at row 15 in the active phase, vdisp_no goes to 1 and row_o reloads to 12 in the same edge.
- R5: While vdisp_no is 1, row_o counts 12 through 15. The row step at 15 returns vdisp_no to 0 and row_o to 0.
- R6: The timing repeats every 260 line pulses: 16 active rows followed by 4 blanked rows.
- R7: frame_start_o is 1 for exactly the one cycle after the edge on which vdisp_no returns from 1 to 0, and is 0 at all other times.
- R8: Line pulses on back-to-back cycles are each counted. Timing depends only on the number of pulses, not on their spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_adv_i | input | 1 | One-cycle pulse at the end of each scan line |
| row_o | output | 4 | Current character-row count |
| vdisp_no | output | 1 | Display phase flag, 0 = active, 1 = blanked retrace |
| frame_start_o | output | 1 | One-cycle pulse when the active phase begins |

## Verification
Line pulses are applied over three full frames with idle gaps of zero, one and two cycles in a rotating pattern. This separates timing that counts pulses from timing that counts clocks, and exercises back-to-back pulses. The bench computes row, phase and frame-start from the pulse count alone, using the 13-line row and the 16+4 split. This catches a wrong reload value, a wrong row length or a misplaced phase toggle. A long idle stretch shows that nothing moves without pulses. A reset applied mid-frame shows the return to the initial state.

// File: rtl/row_vtiming_pkg.sv
package row_vtiming_pkg;
  typedef enum logic {
    PH_ACTIVE = 1'b0,
    PH_BLANK  = 1'b1
  } phase_e;
endpackage

// File: rtl/row_scan_cnt.sv
module row_scan_cnt #(
  parameter int LINES_PER_ROW = 13,
  localparam int SCAN_W = $clog2(LINES_PER_ROW)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_adv_i,
  output logic wrap_o
);
  localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(LINES_PER_ROW - 1);

  logic [SCAN_W-1:0] scan_q;

  assign wrap_o = line_adv_i && (scan_q == SCAN_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         scan_q <= '0;
    else if (wrap_o)     scan_q <= '0;
    else if (line_adv_i) scan_q <= scan_q + 1'b1;
  end
endmodule

// File: rtl/row_text_cnt.sv
module row_text_cnt #(
  parameter int ROW_W       = 4,
  parameter int ACTIVE_ROWS = 16,
  parameter int BLANK_ROWS  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  row_vtiming_pkg::phase_e phase_i,
  output logic [ROW_W-1:0] row_o,
  output logic             carry_o
);
  import row_vtiming_pkg::*;

  localparam int          MOD         = 1 << ROW_W;
  localparam logic [ROW_W-1:0] ACT_PRESET = ROW_W'(MOD - ACTIVE_ROWS);
  localparam logic [ROW_W-1:0] BLK_PRESET = ROW_W'(MOD - BLANK_ROWS);

  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] preset;

  assign carry_o = &row_q;
  // reload value belongs to the phase being entered
  assign preset  = (phase_i == PH_ACTIVE) ? BLK_PRESET : ACT_PRESET;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_q <= ACT_PRESET;
    else if (step_i) begin
      if (carry_o) row_q <= preset;
      else         row_q <= row_q + 1'b1;
    end
  end

  assign row_o = row_q;
endmodule

// File: rtl/row_phase_ctl.sv
module row_phase_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic carry_i,
  output row_vtiming_pkg::phase_e phase_o,
  output logic frame_start_o
);
  import row_vtiming_pkg::*;

  phase_e phase_q;
  logic   fs_q;
  logic   flip;

  assign flip = step_i && carry_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ACTIVE;
      fs_q    <= 1'b0;
    end else begin
      fs_q <= flip && (phase_q == PH_BLANK);
      if (flip) phase_q <= (phase_q == PH_ACTIVE) ? PH_BLANK : PH_ACTIVE;
    end
  end

  assign phase_o       = phase_q;
  assign frame_start_o = fs_q;
endmodule

// File: rtl/row_vtiming.sv
module row_vtiming #(
  parameter int LINES_PER_ROW = 13,
  parameter int ROW_W         = 4,
  parameter int ACTIVE_ROWS   = 16,
  parameter int BLANK_ROWS    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_adv_i,
  output logic [ROW_W-1:0] row_o,
  output logic             vdisp_no,
  output logic             frame_start_o
);
  import row_vtiming_pkg::*;

  logic   row_step;
  logic   row_carry;
  phase_e phase;

  row_scan_cnt #(.LINES_PER_ROW(LINES_PER_ROW)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_adv_i (line_adv_i),
    .wrap_o     (row_step)
  );

  row_text_cnt #(
    .ROW_W       (ROW_W),
    .ACTIVE_ROWS (ACTIVE_ROWS),
    .BLANK_ROWS  (BLANK_ROWS)
  ) u_rows (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (row_step),
    .phase_i (phase),
    .row_o   (row_o),
    .carry_o (row_carry)
  );

  row_phase_ctl u_phase (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .step_i        (row_step),
    .carry_i       (row_carry),
    .phase_o       (phase),
    .frame_start_o (frame_start_o)
  );

  assign vdisp_no = (phase == PH_BLANK);
endmodule

// File: rtl/row_vtiming_chk.sv
module row_vtiming_chk #(
  parameter int ROW_W       = 4,
  parameter int BLANK_ROWS  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             line_adv_i,
  input logic             row_step,
  input logic [ROW_W-1:0] row_o,
  input logic             vdisp_no,
  input logic             frame_start_o
);
  localparam logic [ROW_W-1:0] BLK_FIRST = ROW_W'((1 << ROW_W) - BLANK_ROWS);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_adv_i |=> $stable(row_o) && $stable(vdisp_no));

  // R2
  step_needs_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_step |-> line_adv_i);

  // R4
  enter_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_step && !vdisp_no && (&row_o)) |=> vdisp_no && row_o == BLK_FIRST);

  // R5
  blank_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vdisp_no |-> row_o >= BLK_FIRST);

  // R5
  leave_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_step && vdisp_no && (&row_o)) |=> !vdisp_no && row_o == '0);

  // R7
  frame_start_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> !vdisp_no && row_o == '0);

  // R7
  frame_start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
endmodule

bind row_vtiming row_vtiming_chk #(
  .ROW_W      (ROW_W),
  .BLANK_ROWS (BLANK_ROWS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .line_adv_i    (line_adv_i),
  .row_step      (row_step),
  .row_o         (row_o),
  .vdisp_no      (vdisp_no),
  .frame_start_o (frame_start_o)
);

// File: tb/row_vtiming_tb.sv
module row_vtiming_tb;
  localparam int LPR   = 13;
  localparam int ACT   = 16;
  localparam int BLK   = 4;
  localparam int FRAME = LPR * (ACT + BLK);

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_adv_i = 1'b0;
  logic [3:0] row_o;
  logic       vdisp_no;
  logic       frame_start_o;

  int n_chk = 0;
  int n_err = 0;
  int pulses = 0;
  bit prev_adv = 1'b0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  row_vtiming u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .line_adv_i    (line_adv_i),
    .row_o         (row_o),
    .vdisp_no      (vdisp_no),
    .frame_start_o (frame_start_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (pulses=%0d)", tag, act, exp, pulses);
    end
  endtask

  // compare outputs against pulse-count model, then drive next input
  task automatic step(input bit adv);
    int f, r, er, ef;
    bit fs;
    @(negedge clk_i);
    f  = pulses % FRAME;
    r  = f / LPR;
    er = (r < ACT) ? r : (16 - BLK) + (r - ACT);
    ef = (r < ACT) ? 0 : 1;
    fs = prev_adv && (f == 0) && (pulses > 0);
    chk(ef ? "R5 blank row" : "R3 active row", int'(row_o), er);
    chk((f == ACT * LPR) ? "R4 phase flag" : "R6 phase flag", int'(vdisp_no), ef);
    chk("R7 frame start", int'(frame_start_o), int'(fs));
    line_adv_i = adv;
    prev_adv   = adv;
    if (adv) pulses++;
  endtask

  initial begin
    // R1 reset state
    #3;
    chk("R1 row in reset", int'(row_o), 0);
    chk("R1 flag in reset", int'(vdisp_no), 0);
    chk("R1 fs in reset", int'(frame_start_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) step(1'b0);

    // R8 gap patterns 0,1,2 over three frames
    for (int i = 0; i < 3 * FRAME; i++) begin
      step(1'b1);
      for (int g = 0; g < (i % 3); g++) step(1'b0);
    end

    // R2 long idle window
    for (int k = 0; k < 40; k++) step(1'b0);

    // partial frame into blanked region, then mid-frame reset
    for (int i = 0; i < LPR * (ACT + 1) + 5; i++) step(1'b1);
    step(1'b0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    line_adv_i = 1'b0;
    #1;
    chk("R1 row after reset", int'(row_o), 0);
    chk("R1 flag after reset", int'(vdisp_no), 0);
    chk("R1 fs after reset", int'(frame_start_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    pulses = 0;
    prev_adv = 1'b0;
    // R1 scan count restarted: row steps after exactly 13 pulses
    for (int i = 0; i < LPR + 2; i++) step(1'b1);
    step(1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule